// File: doc/BRIEF.md
# Video Chip Write Pacer

This block sits between a CPU-side byte write request and the write ports of a video display processor that cannot take bytes back to back. Each byte carries a two-bit target port. The block follows the sequence of writes in progress and withholds `wr_ready` until enough cycles have passed since the last byte it forwarded. Two bytes to the control port form a setup pair. A run of bytes to the indirect register port forms a bulk register stream. Bytes to the data port or the palette port form a memory data stream.

The required gap comes from the sequence state and the port of the waiting byte, never from a fixed constant. Two bytes inside a setup pair, or two bulk register bytes in a row, need only the short gap. The byte after a completed pair needs the long gap. Any byte after a data byte needs the long gap, and so does leaving a bulk stream for another port. A request that arrives too early is stalled and is not lost. The bytes that the block accepts come out one cycle later as a single-cycle strobe with their port and byte. Both gaps are given in nanoseconds and become cycle counts through a clock-frequency parameter. A long silence or a synchronous reset returns the tracker to its idle state.

Top module: `vdp_write_pacer`

## Requirements
- R1: Right after a synchronous reset, `wr_ready` is high and `vdp_wr` is low.
- R2: Each request accepted (`wr_req` and `wr_ready` high at a clock edge) produces exactly one `vdp_wr` pulse in the following cycle. The pulse carries the accepted port and byte. No pulse appears otherwise.
- R3: Port encoding is 0 data, 1 control, 2 palette, 3 indirect register. A byte following a lone control byte (the first of a pair) needs at least SHORT_CYC cycles between acceptances, and the next request is taken after exactly that gap.
- R4: A second consecutive control byte completes a setup pair. The byte after a completed pair needs LONG_CYC cycles, whatever its port.
- R5: After a data-port or palette-port byte, the next byte to any port needs LONG_CYC cycles.
- R6: After an indirect-register byte, another indirect-register byte needs SHORT_CYC cycles, and a byte to any other port needs LONG_CYC cycles.
- R7: A request presented before its gap has elapsed is held. `wr_ready` stays low for gap-1 cycles and then accepts the held byte unchanged.
- R8: Once IDLE_CYC cycles have passed since the last acceptance with no new write, the tracker is idle. The next control byte then starts a new pair. Below that limit, the sequence state is kept.
- R9: A synchronous reset in the middle of a sequence returns the tracker to idle: the next byte is accepted at once and a control byte starts a new pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | CPU byte write request, held until accepted |
| wr_port | input | 2 | Target port of the request |
| wr_data | input | 8 | Byte to write |
| wr_ready | output | 1 | High when the request can be taken this cycle |
| vdp_wr | output | 1 | Single-cycle forwarded write strobe |
| vdp_port | output | 2 | Port of the forwarded byte |
| vdp_data | output | 8 | Forwarded byte |

## Verification
The bench builds the block with a 4 MHz clock parameter, which gives an 8-cycle short gap and a 32-cycle long gap, and with an idle limit of 64 cycles. These small values let each back-to-back request land exactly on its gap boundary within a few dozen cycles. Every state transition is exercised, including leaving a bulk stream and the byte after a completed pair. The short idle limit allows a test to wait just below the timeout, where the state must be kept, and just beyond it, where a control byte must start a fresh pair.

// File: rtl/vwp_pkg.sv
package vwp_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned PORT_W = 2;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_HALF,
        SQ_PAIR,
        SQ_STREAM,
        SQ_BULK
    } seq_t;

    typedef enum logic [1:0] {
        PK_DATA = 2'd0,
        PK_CTRL = 2'd1,
        PK_PAL  = 2'd2,
        PK_IREG = 2'd3
    } port_kind_t;

    typedef enum logic [1:0] {
        GAP_NONE,
        GAP_SHORT,
        GAP_LONG
    } gap_t;

    typedef struct packed {
        logic [PORT_W-1:0] port;
        logic [BYTE_W-1:0] data;
    } wr_beat_t;

    // Round a duration up to whole clock cycles.
    function automatic int unsigned ns_to_cycles(int unsigned khz, int unsigned ns);
        return (khz * ns + 32'd999_999) / 32'd1_000_000;
    endfunction

    // Gap class needed before a byte of kind k while in state s.
    function automatic gap_t gap_for(seq_t s, port_kind_t k);
        gap_t g;
        case (s)
            SQ_IDLE:   g = GAP_NONE;
            SQ_HALF:   g = GAP_SHORT;
            SQ_PAIR:   g = GAP_LONG;
            SQ_STREAM: g = GAP_LONG;
            SQ_BULK:   g = (k == PK_IREG) ? GAP_SHORT : GAP_LONG;
            default:   g = GAP_LONG;
        endcase
        return g;
    endfunction

    // Sequence state after forwarding a byte of kind k.
    function automatic seq_t seq_next(seq_t s, port_kind_t k);
        seq_t n;
        case (k)
            PK_CTRL: n = (s == SQ_HALF) ? SQ_PAIR : SQ_HALF;
            PK_IREG: n = SQ_BULK;
            default: n = SQ_STREAM;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/vwp_gap_timer.sv
module vwp_gap_timer #(
    parameter int unsigned CNT_W = 9,
    parameter int unsigned SAT   = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic [CNT_W-1:0] need_cyc,
    output logic             elapsed,
    output logic             timed_out
);
    localparam logic [CNT_W-1:0] SAT_C = CNT_W'(SAT);
    localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

    logic [CNT_W-1:0] since_q;

    // Cycles since the last accepted byte, saturating at the idle limit.
    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= SAT_C;
        end else if (accept) begin
            since_q <= ONE_C;
        end else if (since_q < SAT_C) begin
            since_q <= since_q + ONE_C;
        end
    end

    assign elapsed   = (since_q >= need_cyc);
    assign timed_out = (since_q >= SAT_C);

endmodule

// File: rtl/vwp_seq_tracker.sv
module vwp_seq_tracker
    import vwp_pkg::*;
#(
    parameter int unsigned CNT_W     = 9,
    parameter int unsigned SHORT_CYC = 16,
    parameter int unsigned LONG_CYC  = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [PORT_W-1:0] probe_port,
    input  logic              timed_out,
    output logic [CNT_W-1:0]  need_cyc
);
    localparam logic [CNT_W-1:0] SHORT_C = CNT_W'(SHORT_CYC);
    localparam logic [CNT_W-1:0] LONG_C  = CNT_W'(LONG_CYC);

    seq_t       state_q;
    port_kind_t probe_kind;
    gap_t       gap_sel;

    assign probe_kind = port_kind_t'(probe_port);

    // The byte waiting at the input decides the gap and, once taken, the next state.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
        end else if (accept) begin
            state_q <= seq_next(state_q, probe_kind);
        end else if (timed_out) begin
            state_q <= SQ_IDLE;
        end
    end

    assign gap_sel = gap_for(state_q, probe_kind);

    always_comb begin
        case (gap_sel)
            GAP_NONE:  need_cyc = '0;
            GAP_SHORT: need_cyc = SHORT_C;
            default:   need_cyc = LONG_C;
        endcase
    end

endmodule

// File: rtl/vwp_out_stage.sv
module vwp_out_stage
    import vwp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     accept,
    input  wr_beat_t beat_in,
    output logic     strobe,
    output wr_beat_t beat_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            strobe   <= 1'b0;
            beat_out <= '0;
        end else begin
            strobe <= accept;
            if (accept) begin
                beat_out <= beat_in;
            end
        end
    end

endmodule

// File: rtl/vdp_write_pacer.sv
module vdp_write_pacer
    import vwp_pkg::*;
#(
    parameter int unsigned CLK_KHZ  = 8000,
    parameter int unsigned SHORT_NS = 2000,
    parameter int unsigned LONG_NS  = 8000,
    parameter int unsigned IDLE_CYC = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_req,
    input  logic [PORT_W-1:0] wr_port,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              wr_ready,
    output logic              vdp_wr,
    output logic [PORT_W-1:0] vdp_port,
    output logic [BYTE_W-1:0] vdp_data
);
    localparam int unsigned SHORT_CYC = ns_to_cycles(CLK_KHZ, SHORT_NS);
    localparam int unsigned LONG_CYC  = ns_to_cycles(CLK_KHZ, LONG_NS);
    localparam int unsigned CNT_W     = $clog2(IDLE_CYC + 1);

    logic             accept;
    logic             elapsed;
    logic             timed_out;
    logic [CNT_W-1:0] need_cyc;
    wr_beat_t         beat_in;
    wr_beat_t         beat_out;

    assign wr_ready = elapsed;
    assign accept   = wr_req & elapsed;
    assign beat_in  = '{port: wr_port, data: wr_data};

    vwp_gap_timer #(
        .CNT_W (CNT_W),
        .SAT   (IDLE_CYC)
    ) timer_i (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .need_cyc  (need_cyc),
        .elapsed   (elapsed),
        .timed_out (timed_out)
    );

    vwp_seq_tracker #(
        .CNT_W     (CNT_W),
        .SHORT_CYC (SHORT_CYC),
        .LONG_CYC  (LONG_CYC)
    ) seq_i (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .probe_port (wr_port),
        .timed_out  (timed_out),
        .need_cyc   (need_cyc)
    );

    vwp_out_stage out_i (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .beat_in  (beat_in),
        .strobe   (vdp_wr),
        .beat_out (beat_out)
    );

    assign vdp_port = beat_out.port;
    assign vdp_data = beat_out.data;

endmodule

// File: rtl/vdp_write_pacer_chk.sv
module vdp_write_pacer_chk #(
    parameter int unsigned SHORT_CYC = 16,
    parameter int unsigned LONG_CYC  = 64,
    parameter int unsigned IDLE_CYC  = 256
) (
    input logic       clk,
    input logic       rst,
    input logic       wr_req,
    input logic       wr_ready,
    input logic [1:0] wr_port,
    input logic [7:0] wr_data,
    input logic       vdp_wr,
    input logic [1:0] vdp_port,
    input logic [7:0] vdp_data
);
    localparam int unsigned CW = $clog2(IDLE_CYC + 1);
    localparam logic [CW-1:0] IDLE_C  = CW'(IDLE_CYC);
    localparam logic [CW-1:0] SHORT_C = CW'(SHORT_CYC);
    localparam logic [CW-1:0] LONG_C  = CW'(LONG_CYC);
    localparam logic [CW-1:0] ONE_C   = CW'(1);

    logic [CW-1:0] gap_cnt;
    logic [1:0]    prev_port;
    logic          have_prev;
    logic          live;

    // Own measurement of spacing between forwarded strobes.
    always_ff @(posedge clk) begin
        if (rst) begin
            gap_cnt   <= IDLE_C;
            prev_port <= 2'd0;
            have_prev <= 1'b0;
        end else if (vdp_wr) begin
            gap_cnt   <= ONE_C;
            prev_port <= vdp_port;
            have_prev <= 1'b1;
        end else if (gap_cnt < IDLE_C) begin
            gap_cnt <= gap_cnt + ONE_C;
        end
    end

    assign live = have_prev && (gap_cnt < IDLE_C);

    a_r1_ready_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (wr_ready && !vdp_wr));

    a_r2_forward: assert property (@(posedge clk) disable iff (rst)
        (wr_req && wr_ready) |=> (vdp_wr && vdp_port == $past(wr_port)
                                  && vdp_data == $past(wr_data)));

    a_r2_no_extra: assert property (@(posedge clk) disable iff (rst)
        !(wr_req && wr_ready) |=> !vdp_wr);

    a_r3_min_short: assert property (@(posedge clk) disable iff (rst)
        (vdp_wr && live) |-> (gap_cnt >= SHORT_C));

    a_r5_long_after_data: assert property (@(posedge clk) disable iff (rst)
        (vdp_wr && live && !prev_port[0]) |-> (gap_cnt >= LONG_C));

    a_r6_bulk_exit: assert property (@(posedge clk) disable iff (rst)
        (vdp_wr && live && prev_port == 2'd3 && vdp_port != 2'd3) |-> (gap_cnt >= LONG_C));

endmodule

bind vdp_write_pacer vdp_write_pacer_chk #(
    .SHORT_CYC (SHORT_CYC),
    .LONG_CYC  (LONG_CYC),
    .IDLE_CYC  (IDLE_CYC)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .wr_req   (wr_req),
    .wr_ready (wr_ready),
    .wr_port  (wr_port),
    .wr_data  (wr_data),
    .vdp_wr   (vdp_wr),
    .vdp_port (vdp_port),
    .vdp_data (vdp_data)
);

// File: tb/vdp_write_pacer_tb_top.sv
module vdp_write_pacer_tb_top;

    localparam int SHORT = 8;
    localparam int LONG  = 32;
    localparam int IDLE  = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_req = 1'b0;
    logic [1:0] wr_port = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       wr_ready;
    logic       vdp_wr;
    logic [1:0] vdp_port;
    logic [7:0] vdp_data;

    always #4 clk = ~clk;

    vdp_write_pacer #(
        .CLK_KHZ  (4000),
        .SHORT_NS (2000),
        .LONG_NS  (8000),
        .IDLE_CYC (IDLE)
    ) dut_i (
        .clk      (clk),
        .rst      (rst),
        .wr_req   (wr_req),
        .wr_port  (wr_port),
        .wr_data  (wr_data),
        .wr_ready (wr_ready),
        .vdp_wr   (vdp_wr),
        .vdp_port (vdp_port),
        .vdp_data (vdp_data)
    );

    typedef struct {
        logic [1:0] port;
        logic [7:0] data;
        int         gap;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;
    int   last_pulse = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Monitor: pops expected beats and measures strobe spacing.
    always @(negedge clk) begin
        if (!rst && vdp_wr) begin
            if (q.size() == 0) begin
                chk(1'b0, "R2", "unexpected strobe", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(vdp_port == e.port, "R2", "port", int'(vdp_port), int'(e.port));
                chk(vdp_data == e.data, "R2", "data", int'(vdp_data), int'(e.data));
                if (e.gap > 0)
                    chk((cyc - last_pulse) == e.gap, e.tag, "gap", cyc - last_pulse, e.gap);
            end
            last_pulse = cyc;
        end
    end

    // Driver: called at a falling edge; returns at the falling edge after acceptance.
    task automatic send(input logic [1:0] p, input logic [7:0] d, input int gap, input string tag);
        int lows;
        exp_t e;
        e.port = p; e.data = d; e.gap = gap; e.tag = tag;
        q.push_back(e);
        wr_req = 1'b1; wr_port = p; wr_data = d;
        lows = 0;
        #1;
        while (!wr_ready) begin
            lows++;
            @(negedge clk);
            #1;
        end
        if (gap > 0) chk(lows == gap - 1, "R7", "stall cycles", lows, gap - 1);
        @(posedge clk);
        @(negedge clk);
        wr_req = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
    endtask

    task automatic run_all();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(wr_ready == 1'b1, "R1", "ready after reset", int'(wr_ready), 1);
        chk(vdp_wr == 1'b0, "R1", "strobe after reset", int'(vdp_wr), 0);
        @(negedge clk);

        send(2'd1, 8'h11, 0, "R3");
        send(2'd1, 8'h87, SHORT, "R3");
        send(2'd0, 8'hA1, LONG, "R4");
        send(2'd0, 8'hA2, LONG, "R5");
        send(2'd2, 8'hA3, LONG, "R5");
        send(2'd1, 8'h05, LONG, "R5");
        send(2'd1, 8'h91, SHORT, "R3");
        send(2'd3, 8'h31, LONG, "R4");
        send(2'd3, 8'h32, SHORT, "R6");
        send(2'd3, 8'h33, SHORT, "R6");
        send(2'd0, 8'hB0, LONG, "R6");
        send(2'd1, 8'h22, LONG, "R5");
        send(2'd3, 8'h34, SHORT, "R3");
        send(2'd1, 8'h44, LONG, "R6");
        send(2'd0, 8'hB1, SHORT, "R3");
        drain();

        // Below the idle limit the pair state is kept.
        send(2'd1, 8'h55, 0, "R8");
        idle(40);
        send(2'd1, 8'h56, 0, "R8");
        send(2'd0, 8'hC0, LONG, "R8");
        drain();

        // Beyond the idle limit a control byte starts a new pair.
        send(2'd1, 8'h57, 0, "R8");
        idle(IDLE + 4);
        send(2'd1, 8'h58, 0, "R8");
        send(2'd0, 8'hC1, SHORT, "R8");
        drain();

        // Reset in the middle of a pair.
        send(2'd1, 8'h59, 0, "R9");
        drain();
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        #1;
        chk(wr_ready == 1'b1, "R9", "ready after mid-sequence reset", int'(wr_ready), 1);
        @(negedge clk);
        send(2'd1, 8'h5A, 0, "R9");
        send(2'd0, 8'hC2, SHORT, "R9");
        drain();
        idle(4);
        chk(q.size() == 0, "R2", "outstanding beats", q.size(), 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                chk(1'b0, "R2", "watchdog expired", 1, 0);
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule